// File: doc/BRIEF.md
# Serial Port Register Block

This block is the register-level face of a byte-oriented serial port. A host reaches it through a 32-bit register bus with a select, a write flag and a 6-bit byte offset. The block sends a byte out on a transmit stream each time the host writes the transmit-data register. It takes incoming bytes on a receive stream that uses a valid/ready handshake. It raises one level-sensitive interrupt line.

Bit serialization, baud timing and DMA transfers are handled elsewhere. The DMA-enable word here is only storage. The block keeps a raw interrupt word: bit 0 is the transmit event and bit 3 is the receive event. A mask selects which raw bits drive the interrupt line, and a self-clearing acknowledge write removes raw bits. Received data and receiver status share one word, which can be read at two offsets. One offset clears data-available as a side effect of the read. The other offset only observes the word.

Top module: `sport_regs`

## Requirements
- R1: After reset the interrupt line is 0 and `rxReady` is 1. The status word reads 0x0140_0000: transmitter-ready (bit 24) and transmitter-idle (bit 22) are 1, everything else is 0. Every other register reads 0.
- R2: The transmit-control (0x00), DMA-enable (0x04), receive-control (0x08) and mask (0x2C) registers read back the last value written. The acknowledge offset (0x30) always reads 0.
- R3: Reads of any offset not listed in R2 or R6, and not 0x34 or 0x38, return 0. This includes offsets with bits 1:0 nonzero. Writes to those offsets change no register.
- R4: A write to 0x1C gives `txValid` high for exactly the one cycle after the write edge, with `txByte` equal to the low 8 bits of the write data. It also sets raw interrupt bit 0 and a hidden transmit-pending flag.
- R5: A receive byte is taken on an edge where `rxValid` and `rxReady` are both 1. Taking it puts the byte in status bits 7:0, sets data-available (bit 16) and sets raw interrupt bit 3.
- R6: A read at 0x20 returns the status word and then clears data-available. A read at 0x24 returns the same word and changes nothing.
- R7: `rxReady` equals receive-control bit 0 OR NOT raw bit 3. A byte offered while `rxReady` is 0 leaves the status word unchanged.
- R8: A write to 0x30 clears every raw bit where the write data is 1, subject to R9. Writes to other offsets clear no raw bit. The raw word reads at 0x34.
- R9: An acknowledge with bit 0 set while transmit-pending is set leaves raw bit 0 at 1 and clears transmit-pending. A later such acknowledge then clears raw bit 0.
- R10: Offset 0x38 reads raw AND mask. The `irq` output is a register that is 1 exactly when that value is nonzero, and it changes on the same edge as the raw or mask word.
- R11: A byte taken on the same edge as an acknowledge of bit 3 leaves raw bit 3 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from offset |
| txValid | output | 1 | One-cycle transmit byte strobe |
| txByte | output | 8 | Transmit byte |
| rxValid | input | 1 | Receive byte offered |
| rxByte | input | 8 | Receive byte |
| rxReady | output | 1 | Receive byte can be taken |
| irq | output | 1 | Interrupt level |

## Verification
Read data is combinational, so the bench samples `busRdata` in the cycle the read is driven, just before the edge that applies any read-clear. Register writes, raw and masked interrupt bits, `irq`, `txValid` and `txByte` all change on the edge that ends the access. They are therefore sampled at the falling edge one half-period after it. `rxReady` depends on current state only and is sampled while the offer is held, before the edge that takes the byte. A reference model in the bench advances by one access or offer at a time, in that same order, so each expected value matches the cycle in which it is read.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_TXCTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_DMAEN  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_RXCTRL = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_TXDATA = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_STATRC = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h2C;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 6'h30;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 6'h34;
  localparam logic [ADDR_W-1:0] OFF_MASKED = 6'h38;

  localparam int unsigned BIT_DAV    = 16;
  localparam int unsigned BIT_TXIDLE = 22;
  localparam int unsigned BIT_TXRDY  = 24;
  localparam int unsigned IRQ_TX     = 0;
  localparam int unsigned IRQ_RX     = 3;

  typedef struct packed {
    logic wrTxCtrl;
    logic wrDmaEn;
    logic wrRxCtrl;
    logic wrTxData;
    logic wrMask;
    logic wrAck;
    logic rdClrDav;
    logic rxTake;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TXCTRL,
    SEL_DMAEN,
    SEL_RXCTRL,
    SEL_STAT,
    SEL_MASK,
    SEL_RAW,
    SEL_MASKED
  } rdsel_t;
endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rxValid,
  input  logic              rxReady,
  output strobe_t           strb,
  output rdsel_t            rdSel
);
  logic doWr;
  logic doRd;

  assign doWr = busSel & busWr;
  assign doRd = busSel & ~busWr;

  always_comb begin
    strb          = '0;
    strb.rxTake   = rxValid & rxReady;
    rdSel         = SEL_NONE;
    case (busAddr)
      OFF_TXCTRL: begin strb.wrTxCtrl = doWr; rdSel = SEL_TXCTRL; end
      OFF_DMAEN:  begin strb.wrDmaEn  = doWr; rdSel = SEL_DMAEN;  end
      OFF_RXCTRL: begin strb.wrRxCtrl = doWr; rdSel = SEL_RXCTRL; end
      OFF_TXDATA: strb.wrTxData = doWr;
      OFF_STATRC: begin strb.rdClrDav = doRd; rdSel = SEL_STAT; end
      OFF_STAT:   rdSel = SEL_STAT;
      OFF_MASK:   begin strb.wrMask   = doWr; rdSel = SEL_MASK;   end
      OFF_ACK:    strb.wrAck = doWr;
      OFF_RAW:    rdSel = SEL_RAW;
      OFF_MASKED: rdSel = SEL_MASKED;
      default:    rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sport_dpath.sv
module sport_dpath
  import sport_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  rdsel_t            rdSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              rxReady,
  output logic              irq
);
  localparam logic [DATA_W-1:0] TX_CONST =
    (DATA_W'(1) << BIT_TXRDY) | (DATA_W'(1) << BIT_TXIDLE);

  logic [DATA_W-1:0] txCtrlQ, dmaEnQ, rxCtrlQ, maskQ, rawQ, maskedQ;
  logic [BYTE_W-1:0] rxDataQ;
  logic              davQ, pendQ;

  logic [DATA_W-1:0] rawN, maskN, ackVal, statWord;
  logic              pendN, davN;

  assign rxReady = rxCtrlQ[0] | ~rawQ[IRQ_RX];

  always_comb begin
    rawN   = rawQ;
    pendN  = pendQ;
    ackVal = '0;
    if (strb.wrTxData) begin
      rawN[IRQ_TX] = 1'b1;
      pendN        = 1'b1;
    end
    if (strb.wrAck) begin
      ackVal = busWdata;
      if (pendQ && ackVal[IRQ_TX]) begin
        rawN[IRQ_TX]   = 1'b1;
        pendN          = 1'b0;
        ackVal[IRQ_TX] = 1'b0;
      end
    end
    rawN = rawN & ~ackVal;
    if (strb.rxTake) rawN[IRQ_RX] = 1'b1;
    maskN = strb.wrMask ? busWdata : maskQ;
    davN  = strb.rxTake ? 1'b1 : (strb.rdClrDav ? 1'b0 : davQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCtrlQ <= '0;
      dmaEnQ  <= '0;
      rxCtrlQ <= '0;
      maskQ   <= '0;
      rawQ    <= '0;
      maskedQ <= '0;
      rxDataQ <= '0;
      davQ    <= 1'b0;
      pendQ   <= 1'b0;
      txValid <= 1'b0;
      txByte  <= '0;
      irq     <= 1'b0;
    end else begin
      if (strb.wrTxCtrl) txCtrlQ <= busWdata;
      if (strb.wrDmaEn)  dmaEnQ  <= busWdata;
      if (strb.wrRxCtrl) rxCtrlQ <= busWdata;
      if (strb.rxTake)   rxDataQ <= rxByte;
      maskQ   <= maskN;
      rawQ    <= rawN;
      maskedQ <= rawN & maskN;
      irq     <= |(rawN & maskN);
      davQ    <= davN;
      pendQ   <= pendN;
      txValid <= strb.wrTxData;
      if (strb.wrTxData) txByte <= busWdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    statWord                 = TX_CONST;
    statWord[BIT_DAV]        = davQ;
    statWord[BYTE_W-1:0]     = rxDataQ;
  end

  always_comb begin
    case (rdSel)
      SEL_TXCTRL: busRdata = txCtrlQ;
      SEL_DMAEN:  busRdata = dmaEnQ;
      SEL_RXCTRL: busRdata = rxCtrlQ;
      SEL_STAT:   busRdata = statWord;
      SEL_MASK:   busRdata = maskQ;
      SEL_RAW:    busRdata = rawQ;
      SEL_MASKED: busRdata = maskedQ;
      default:    busRdata = '0;
    endcase
  end

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTxData |=> txValid && txByte == $past(busWdata[BYTE_W-1:0])); // R4
  AST_TX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrTxData |=> !txValid); // R4
  AST_RX_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxTake |=> davQ && rawQ[IRQ_RX] && rxDataQ == $past(rxByte)); // R5
  AST_RDCLR_DAV: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdClrDav && !strb.rxTake |=> !davQ); // R6
  AST_PEND_REARM: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAck && busWdata[IRQ_TX] && pendQ |=> rawQ[IRQ_TX] && !pendQ); // R9
  AST_ACK_CLEARS_RX: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAck && busWdata[IRQ_RX] && !strb.rxTake |=> !rawQ[IRQ_RX]); // R8
  AST_RX_WINS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxTake && strb.wrAck |=> rawQ[IRQ_RX]); // R11
  AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxTake && !strb.wrMask && maskQ[IRQ_RX] |=> irq); // R10
endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        txValid,
  output logic [7:0]  txByte,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  output logic        rxReady,
  output logic        irq
);
  strobe_t strb;
  rdsel_t  rdSel;

  sport_ctrl u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .rxValid (rxValid),
    .rxReady (rxReady),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  sport_dpath #(.DATA_W(32), .BYTE_W(8)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .rxByte   (rxByte),
    .busRdata (busRdata),
    .txValid  (txValid),
    .txByte   (txByte),
    .rxReady  (rxReady),
    .irq      (irq)
  );
endmodule

// File: tb/sim_sport_regs.sv
module sim_sport_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txValid, rxReady, irq;
  logic [7:0]  txByte;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;

  int nChecks = 0, nBad = 0;
  bit finished = 0;

  logic [31:0] mTxCtrl = 0, mDma = 0, mRec = 0, mMask = 0, mRaw = 0;
  logic        mPend = 0, mDav = 0;
  logic [7:0]  mRxd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_regs u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txValid(txValid), .txByte(txByte),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] statWord();
    return 32'h0140_0000 | (32'(mDav) << 16) | 32'(mRxd);
  endfunction

  function automatic logic [31:0] expRead(input logic [5:0] a);
    case (a)
      6'h00: return mTxCtrl;
      6'h04: return mDma;
      6'h08: return mRec;
      6'h20, 6'h24: return statWord();
      6'h2C: return mMask;
      6'h34: return mRaw;
      6'h38: return mRaw & mMask;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(input logic [5:0] a);
    case (a)
      6'h00, 6'h04, 6'h08, 6'h2C, 6'h30: return "R2";
      6'h20, 6'h24: return "R6";
      6'h34: return "R8";
      6'h38: return "R10";
      default: return "R3";
    endcase
  endfunction

  function automatic logic modelReady();
    return mRec[0] | ~mRaw[3];
  endfunction

  task automatic modelWrite(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] ack;
    ack = 0;
    case (a)
      6'h00: mTxCtrl = d;
      6'h04: mDma = d;
      6'h08: mRec = d;
      6'h1C: begin mRaw[0] = 1'b1; mPend = 1'b1; end
      6'h2C: mMask = d;
      6'h30: begin
        ack = d;
        if (mPend && ack[0]) begin mPend = 1'b0; ack[0] = 1'b0; end
      end
      default: ;
    endcase
    mRaw = mRaw & ~ack;
  endtask

  task automatic modelRx(input logic [7:0] b);
    mRxd = b; mDav = 1'b1; mRaw[3] = 1'b1;
  endtask

  task automatic postChecks(input logic txExp, input logic [7:0] txB);
    check("R4", 32'(txValid), 32'(txExp));
    if (txExp) check("R4", 32'(txByte), 32'(txB));
    check("R10", 32'(irq), 32'(|(mRaw & mMask)));
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
    modelWrite(a, d);
    postChecks(a == 6'h1C, d[7:0]);
  endtask

  task automatic doRead(input logic [5:0] a);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 check(reqOf(a), busRdata, expRead(a));
    @(negedge clk);
    busSel = 0;
    if (a == 6'h20) mDav = 1'b0;
    postChecks(1'b0, 8'h0);
  endtask

  task automatic doRx(input logic [7:0] b);
    logic rdy;
    @(negedge clk);
    rxValid = 1; rxByte = b;
    rdy = modelReady();
    #1 check("R7", 32'(rxReady), 32'(rdy));
    @(negedge clk);
    rxValid = 0;
    if (rdy) modelRx(b);
    postChecks(1'b0, 8'h0);
  endtask

  task automatic ackWithRx(input logic [31:0] d, input logic [7:0] b);
    logic rdy;
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 6'h30; busWdata = d;
    rxValid = 1; rxByte = b;
    rdy = modelReady();
    #1 check("R7", 32'(rxReady), 32'(rdy));
    @(negedge clk);
    busSel = 0; busWr = 0; rxValid = 0;
    modelWrite(6'h30, d);
    if (rdy) modelRx(b);
    postChecks(1'b0, 8'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nBad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seedVal;
    seedVal = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(irq), 0);
    check("R1", 32'(rxReady), 1);
    busAddr = 6'h24; #1 check("R1", busRdata, 32'h0140_0000);
    busAddr = 6'h34; #1 check("R1", busRdata, 32'h0);
    busAddr = 6'h00;
    // R4/R9 transmit and pending re-arm
    doWrite(6'h2C, 32'h9);
    doWrite(6'h1C, 32'hABCD_125A);
    doRead(6'h34);
    doWrite(6'h30, 32'h1);
    busAddr = 6'h34; #1 check("R9", busRdata, 32'h1);
    doWrite(6'h30, 32'h1);
    busAddr = 6'h34; #1 check("R9", busRdata, 32'h0);
    // R5/R6 receive and the two status views
    doRx(8'hC3);
    busAddr = 6'h24; #1 check("R5", busRdata, 32'h0141_00C3);
    doRead(6'h24);
    doRead(6'h20);
    doRead(6'h24);
    // R7 receiver not ready keeps old byte
    doRx(8'h11);
    busAddr = 6'h24; #1 check("R7", busRdata, 32'h0140_00C3);
    doWrite(6'h08, 32'h1);
    doRx(8'h22);
    // R11 ack of bit 3 on the same edge as a taken byte
    ackWithRx(32'h8, 8'h33);
    busAddr = 6'h34; #1 check("R11", busRdata & 32'h8, 32'h8);
    // R3 unmapped writes and reads
    doWrite(6'h28, 32'hFFFF_FFFF);
    doWrite(6'h3C, 32'hFFFF_FFFF);
    doWrite(6'h01, 32'hFFFF_FFFF);
    foreach (u0.busRdata[i]) if (i < 16) doRead(6'(i * 4));
    doRead(6'h22);
    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      int op;
      logic [5:0] a;
      logic [31:0] d;
      op = int'($urandom % 10);
      a  = 6'(($urandom % 16) * 4);
      d  = $urandom;
      if (($urandom % 4) == 0) d = d & 32'h9;
      if (op < 4)      doWrite(a, d);
      else if (op < 7) doRead(a);
      else             doRx(8'($urandom));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule